// File: doc/BRIEF.md
# Dissemination Barrier Synchronizer

This block makes a group of NUM_PART hardware participants meet at a common point. A participant raises its arrive line for one cycle, and its release line pulses once every participant has reached the same barrier episode. There is no shared arrival counter. Each participant walks through ceil(log2 NUM_PART) pairwise rounds. In round k it writes a flag owned by the participant 2^k positions ahead (modulo NUM_PART), then waits until its own round-k flag has been written by the participant 2^k positions behind.

Flags are single bits that are never cleared. Each participant keeps a sense bit and a bank-select bit. Signalling writes the inverse of the sense bit into the selected bank. The bank bit toggles after every episode, and the sense bit inverts after every second episode. Because of this, back-to-back episodes cannot see stale flags from the episode before. Participants may run ahead of one another, and a participant may arrive at the next episode in the cycle after its release. NUM_PART need not be a power of two.

Top module: `dissem_barrier`

## Requirements
- R1: After reset no release is asserted and every participant is idle. A participant leaves idle only in a cycle where its arrive bit is sampled high.
- R2: No participant's release is asserted until all NUM_PART participants have arrived at the same episode.
- R3: The number of rounds is R = ceil(log2 NUM_PART), and round k signals participant (i + 2^k) mod NUM_PART. If all participants arrive at the same clock edge E, every release is high in the cycle after edge E + 2R. For NUM_PART = 5 this is edge E + 6.
- R4: Release is a one-cycle pulse. It is given exactly once per participant per episode.
- R5: An arrive bit sampled while that participant is not idle has no effect. This covers the cycles spent in rounds and the release cycle itself.
- R6: A participant is idle in the cycle after its release and may arrive at once. With every arrive bit held high, releases repeat every 2R + 2 cycles.
- R7: With staggered arrivals, the last participant to arrive is released exactly 2R edges after its arrival edge. Every other participant is released no later than that, and strictly after the last arrival edge.
- R8: The two flag banks are used alternately and the sense bit reverses every second episode. Any sequence of consecutive episodes completes, whichever bank and sense value it uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | NUM_PART | Bit i: participant i arrives at the barrier (sampled while idle) |
| release_o | output | NUM_PART | Bit i: one-cycle pulse when participant i may leave the barrier |

## Verification
The bench drives a table of arrival patterns. These include simultaneous arrival, rising and falling staircases, a single very late arrival, ties for last place, and an early outlier. Together they push eight consecutive episodes through both banks and both sense values. A design that waited on the wrong bank or the wrong sense value would hang, or would release early in a later episode.

Extra arrive pulses are injected in the middle of the rounds and during the release cycle. Afterwards, the bench shows that the rest of the group stays blocked until that participant truly arrives again. A design that latched those pulses would release the group too soon.

A held arrive line checks the exact re-arm period. An extra or missing idle cycle shifts every later release.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SIGNAL = 2'd1,
        PH_WAIT   = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;

    // Participant that signals participant i in round k.
    function automatic int sender_of(input int i, input int k, input int np);
        int off;
        off = (1 << k) % np;
        return (i - off + np) % np;
    endfunction

    // Participant that participant i signals in round k.
    function automatic int target_of(input int i, input int k, input int np);
        return (i + ((1 << k) % np)) % np;
    endfunction

endpackage

// File: rtl/dsb_part_fsm.sv
module dsb_part_fsm
    import dsb_pkg::*;
#(
    parameter int ROUNDS = 3,
    parameter int RW     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arrive,
    input  logic [1:0][ROUNDS-1:0]     own_flags,
    output logic                       sig_en,
    output logic [RW-1:0]              sig_round,
    output logic                       sig_bank,
    output logic                       sig_value,
    output logic                       release_pulse,
    output logic                       busy
);

    localparam logic [RW-1:0] LAST_ROUND = RW'(ROUNDS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [RW-1:0] round;
        logic          parity;
        logic          sense;
    } part_st_t;

    part_st_t st_d, st_q;
    logic     flag_seen;

    always_comb begin
        st_d          = st_q;
        sig_en        = 1'b0;
        release_pulse = 1'b0;
        flag_seen     = (own_flags[st_q.parity][st_q.round] != st_q.sense);
        case (st_q.phase)
            PH_IDLE: begin
                if (arrive) begin
                    st_d.phase = PH_SIGNAL;
                    st_d.round = '0;
                end
            end
            PH_SIGNAL: begin
                sig_en     = 1'b1;
                st_d.phase = PH_WAIT;
            end
            PH_WAIT: begin
                if (flag_seen) begin
                    if (st_q.round == LAST_ROUND) begin
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.round = st_q.round + 1'b1;
                        st_d.phase = PH_SIGNAL;
                    end
                end
            end
            PH_DONE: begin
                release_pulse = 1'b1;
                st_d.parity   = ~st_q.parity;
                st_d.sense    = st_q.sense ^ st_q.parity;
                st_d.round    = '0;
                st_d.phase    = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, round: '0, parity: 1'b0, sense: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_round = st_q.round;
    assign sig_bank  = st_q.parity;
    assign sig_value = ~st_q.sense;
    assign busy      = (st_q.phase != PH_IDLE);

endmodule

// File: rtl/dsb_flag_store.sv
module dsb_flag_store
    import dsb_pkg::*;
#(
    parameter int NUM_PART = 5,
    parameter int ROUNDS   = 3,
    parameter int RW       = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_PART-1:0]                    sig_en,
    input  logic [NUM_PART-1:0][RW-1:0]            sig_round,
    input  logic [NUM_PART-1:0]                    sig_bank,
    input  logic [NUM_PART-1:0]                    sig_value,
    output logic [1:0][NUM_PART-1:0][ROUNDS-1:0]   flags_o
);

    logic [1:0][NUM_PART-1:0][ROUNDS-1:0] flag_d, flag_q;
    logic [1:0][NUM_PART-1:0][ROUNDS-1:0] hit;
    logic [1:0][NUM_PART-1:0][ROUNDS-1:0] hit_val;

    // Every flag has exactly one writer: the sender for its round.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar j = 0; j < NUM_PART; j++) begin : g_owner
            for (genvar k = 0; k < ROUNDS; k++) begin : g_round
                localparam int WR = sender_of(j, k, NUM_PART);
                assign hit[b][j][k] = sig_en[WR]
                                    && (sig_round[WR] == RW'(k))
                                    && (sig_bank[WR] == 1'(b));
                assign hit_val[b][j][k] = sig_value[WR];
            end
        end
    end

    always_comb begin
        flag_d = flag_q;
        for (int b = 0; b < 2; b++) begin
            for (int j = 0; j < NUM_PART; j++) begin
                for (int k = 0; k < ROUNDS; k++) begin
                    if (hit[b][j][k]) begin
                        flag_d[b][j][k] = hit_val[b][j][k];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/dissem_barrier.sv
module dissem_barrier
    import dsb_pkg::*;
#(
    parameter int NUM_PART = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] arrive_i,
    output logic [NUM_PART-1:0] release_o
);

    localparam int ROUNDS = (NUM_PART < 2) ? 1 : $clog2(NUM_PART);
    localparam int RW     = (ROUNDS < 2) ? 1 : $clog2(ROUNDS);

    logic [NUM_PART-1:0]                  sig_en;
    logic [NUM_PART-1:0][RW-1:0]          sig_round;
    logic [NUM_PART-1:0]                  sig_bank;
    logic [NUM_PART-1:0]                  sig_value;
    logic [NUM_PART-1:0]                  busy_vec;
    logic [1:0][NUM_PART-1:0][ROUNDS-1:0] flags;
    logic [NUM_PART-1:0][1:0][ROUNDS-1:0] own_flags;

    dsb_flag_store #(
        .NUM_PART (NUM_PART),
        .ROUNDS   (ROUNDS),
        .RW       (RW)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_en    (sig_en),
        .sig_round (sig_round),
        .sig_bank  (sig_bank),
        .sig_value (sig_value),
        .flags_o   (flags)
    );

    for (genvar i = 0; i < NUM_PART; i++) begin : g_part
        for (genvar b = 0; b < 2; b++) begin : g_view
            assign own_flags[i][b] = flags[b][i];
        end

        dsb_part_fsm #(
            .ROUNDS (ROUNDS),
            .RW     (RW)
        ) u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .arrive        (arrive_i[i]),
            .own_flags     (own_flags[i]),
            .sig_en        (sig_en[i]),
            .sig_round     (sig_round[i]),
            .sig_bank      (sig_bank[i]),
            .sig_value     (sig_value[i]),
            .release_pulse (release_o[i]),
            .busy          (busy_vec[i])
        );
    end

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
#(
    parameter int NUM_PART = 5,
    parameter int ROUNDS   = 3,
    parameter int RW       = 2
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_PART-1:0]                  arrive_i,
    input logic [NUM_PART-1:0]                  release_o,
    input logic [NUM_PART-1:0]                  busy_vec,
    input logic [NUM_PART-1:0]                  sig_en,
    input logic [NUM_PART-1:0][RW-1:0]          sig_round,
    input logic [NUM_PART-1:0]                  sig_bank,
    input logic [NUM_PART-1:0]                  sig_value,
    input logic [1:0][NUM_PART-1:0][ROUNDS-1:0] flags
);

    logic [NUM_PART-1:0][15:0] acc_q;
    logic [NUM_PART-1:0][15:0] rel_q;
    logic [NUM_PART-1:0]       all_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            rel_q <= '0;
        end else begin
            for (int i = 0; i < NUM_PART; i++) begin
                if (arrive_i[i] && !busy_vec[i]) acc_q[i] <= acc_q[i] + 16'd1;
                if (release_o[i])                rel_q[i] <= rel_q[i] + 16'd1;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_PART; i++) begin
            all_in[i] = 1'b1;
            for (int j = 0; j < NUM_PART; j++) begin
                if ((acc_q[j] - rel_q[i]) == 16'd0 || (acc_q[j] - rel_q[i]) >= 16'h8000) begin
                    all_in[i] = 1'b0;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_PART; i++) begin : g_chk
        assert_leave_idle_on_arrive_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy_vec[i]) |-> $past(arrive_i[i]));

        assert_all_arrived_R2: assert property (@(posedge clk) disable iff (!rst_n)
            release_o[i] |-> all_in[i]);

        assert_release_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
            release_o[i] |=> !release_o[i]);

        assert_idle_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
            release_o[i] |=> !busy_vec[i]);

        for (genvar k = 0; k < ROUNDS; k++) begin : g_rnd
            localparam int TG = target_of(i, k, NUM_PART);
            assert_partner_flag_b0_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (sig_en[i] && sig_round[i] == RW'(k) && !sig_bank[i])
                |=> (flags[0][TG][k] == $past(sig_value[i])));
            assert_partner_flag_b1_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (sig_en[i] && sig_round[i] == RW'(k) && sig_bank[i])
                |=> (flags[1][TG][k] == $past(sig_value[i])));
        end
    end

endmodule

bind dissem_barrier dsb_checker #(
    .NUM_PART (NUM_PART),
    .ROUNDS   (ROUNDS),
    .RW       (RW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arrive_i  (arrive_i),
    .release_o (release_o),
    .busy_vec  (busy_vec),
    .sig_en    (sig_en),
    .sig_round (sig_round),
    .sig_bank  (sig_bank),
    .sig_value (sig_value),
    .flags     (flags)
);

// File: tb/dissem_barrier_tb.sv
`timescale 1ns/1ps
module dissem_barrier_tb;

    localparam int NP  = 5;
    localparam int NR  = $clog2(NP);
    localparam int WIN = 24;
    localparam int NV  = 8;

    // Arrival edge offset of participant i sits in bits [4i+3:4i].
    localparam logic [19:0] VEC [NV] = '{
        20'h00000, 20'h43210, 20'h01234, 20'hC0000,
        20'h99307, 20'h605B2, 20'h11111, 20'h0000A
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive = '0;
    logic [NP-1:0] release_o;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;
    int            total_rel [NP];

    always #2 clk = ~clk;

    dissem_barrier #(.NUM_PART(NP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (arrive),
        .release_o (release_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Returns release as seen after the previous edge, then drives arrive.
    task automatic step(input logic [NP-1:0] a, output logic [NP-1:0] r);
        @(negedge clk);
        r = release_o;
        arrive = a;
        for (int i = 0; i < NP; i++) if (r[i]) total_rel[i]++;
    endtask

    task automatic run_vec(input logic [19:0] offs, input int idx);
        int last;
        int rel_at [NP];
        int rel_n  [NP];
        logic [NP-1:0] a, r;
        last = 0;
        for (int i = 0; i < NP; i++) begin
            rel_at[i] = -1;
            rel_n[i]  = 0;
            if (int'(offs[i*4 +: 4]) > last) last = int'(offs[i*4 +: 4]);
        end
        for (int c = 0; c <= WIN; c++) begin
            for (int i = 0; i < NP; i++) a[i] = (c < WIN) && (int'(offs[i*4 +: 4]) == c);
            step(a, r);
            if (c > 0) begin
                for (int i = 0; i < NP; i++) begin
                    if (r[i]) begin
                        rel_n[i]++;
                        rel_at[i] = c - 1;
                    end
                end
            end
        end
        for (int i = 0; i < NP; i++) begin
            check(rel_n[i] == 1, "R4", $sformatf("vec%0d p%0d release count", idx, i), rel_n[i], 1);
            check(rel_at[i] > last, "R2", $sformatf("vec%0d p%0d release edge after last arrival", idx, i),
                  rel_at[i], last + 1);
            check(rel_at[i] <= last + 2*NR, "R7", $sformatf("vec%0d p%0d release edge bound", idx, i),
                  rel_at[i], last + 2*NR);
            if (int'(offs[i*4 +: 4]) == last) begin
                check(rel_at[i] == last + 2*NR, (idx == 0) ? "R3" : "R7",
                      $sformatf("vec%0d p%0d last-arriver release edge", idx, i), rel_at[i], last + 2*NR);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] r;
        int bad;
        int cnt [NP];
        int at  [NP];
        int early;
        for (int i = 0; i < NP; i++) total_rel[i] = 0;

        // R1: reset state and no spontaneous release
        repeat (3) @(negedge clk);
        check(release_o == '0, "R1", "release during reset", int'(release_o), 0);
        rst_n = 1'b1;
        bad = 0;
        for (int c = 0; c < 20; c++) begin
            step('0, r);
            if (r != '0) bad++;
        end
        check(bad == 0, "R1", "release without arrival", bad, 0);

        // Stimulus table: eight consecutive episodes (R2, R3, R4, R7, R8)
        for (int v = 0; v < NV; v++) run_vec(VEC[v], v);
        for (int i = 0; i < NP; i++)
            check(total_rel[i] == NV, "R8", $sformatf("p%0d releases across alternating banks", i),
                  total_rel[i], NV);

        // R5 part A: extra arrive pulses in rounds (edge 2) and release cycle (edge 7)
        for (int i = 0; i < NP; i++) begin cnt[i] = 0; at[i] = -1; end
        for (int c = 0; c <= 20; c++) begin
            step((c == 0) ? {NP{1'b1}} : ((c == 2 || c == 7) ? NP'(1) : '0), r);
            if (c > 0) for (int i = 0; i < NP; i++) if (r[i]) begin cnt[i]++; at[i] = c - 1; end
        end
        for (int i = 0; i < NP; i++) begin
            check(cnt[i] == 1, "R5", $sformatf("p%0d single release with extra pulses", i), cnt[i], 1);
            check(at[i] == 2*NR, "R5", $sformatf("p%0d release edge with extra pulses", i), at[i], 2*NR);
        end

        // R5 part B: the ignored pulses must not count as an arrival of p0
        for (int i = 0; i < NP; i++) begin cnt[i] = 0; at[i] = -1; end
        early = 0;
        for (int c = 0; c <= 30; c++) begin
            step((c == 0) ? {{(NP-1){1'b1}}, 1'b0} : ((c == 15) ? NP'(1) : '0), r);
            if (c > 0) for (int i = 0; i < NP; i++) if (r[i]) begin
                cnt[i]++; at[i] = c - 1;
                if (c - 1 <= 15) early++;
            end
        end
        check(early == 0, "R5", "release before p0 truly arrived", early, 0);
        check(at[0] == 15 + 2*NR, "R5", "p0 release edge after real arrival", at[0], 15 + 2*NR);
        for (int i = 0; i < NP; i++)
            check(cnt[i] == 1, "R5", $sformatf("p%0d release count after real arrival", i), cnt[i], 1);

        // R6: arrive held high, releases every 2R+2 cycles
        bad = 0;
        for (int i = 0; i < NP; i++) cnt[i] = 0;
        for (int c = 0; c <= 32; c++) begin
            step((c <= 23) ? {NP{1'b1}} : '0, r);
            if (c > 0) begin
                if ((c - 1) == 2*NR || (c - 1) == 4*NR + 2 || (c - 1) == 6*NR + 4) begin
                    if (r != {NP{1'b1}}) bad++;
                end else if (r != '0) begin
                    bad++;
                end
                for (int i = 0; i < NP; i++) if (r[i]) cnt[i]++;
            end
        end
        check(bad == 0, "R6", "back-to-back release pattern mismatches", bad, 0);
        for (int i = 0; i < NP; i++)
            check(cnt[i] == 3, "R6", $sformatf("p%0d back-to-back episodes", i), cnt[i], 3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule